// File: doc/BRIEF.md
# Transaction Attribute Event Filter

This block sits between a stream of observed transactions and a bank of event counters. It decides whether each event should be counted. Every cycle a transaction may be presented with a valid strobe, an event pulse, an 11-bit target identifier, an 11-bit source identifier and a trace-tag flag. The block applies up to three checks, each with its own enable, under one master filter enable. The first is an inclusive target-identifier window. The second is a source-identifier compare in which a mask marks positions that do not matter. The third requires the trace-tag flag. The result is a registered, single-cycle qualified pulse for the counters.

Configuration lives in three 32-bit words that are written and read back through a simple synchronous write port and a combinational read port. The control word is one part of a wider control register shared with the counter logic. Only the filter's own bits are held here, and the remaining bits read as zero.

Top module: `txn_event_filter`

## Requirements
- R1: `cnt_pulse` rises exactly one clock after a cycle in which `txn_valid` and `txn_event` are both 1 and the filter accepts the transaction. It is 0 in any cycle that follows a cycle without both strobes, so a pulse lasts one cycle per qualifying event.
- R2: While the master enable (control bit 1) is 0, every valid event is passed, whatever the other enables and fields hold.
- R3: With the master enable and the target enable (control bit 5) both set, and a valid window, an event passes the target check only when min ≤ target ID ≤ max, with both bounds included.
- R4: A window is valid only when max is nonzero and max ≥ min. With the master and target enables set and an invalid window, no event is passed.
- R5: With the master and source enables set (control bit 4) and a nonzero command value, an event passes the source check only when ((source ID XOR command) AND NOT mask) is zero. A mask bit of 1 makes that position a don't-care.
- R6: With the master and source enables set and a command value of zero, the source check accepts every event.
- R7: With the master and trace-tag enables set (control bit 2), an event passes only when `txn_tag` is 1.
- R8: When several checks are enabled under the master enable, an event passes only when every enabled check accepts it.
- R9: The register layout is as follows. The control word at offset 0x0 holds the master enable in bit 1, the trace-tag enable in bit 2, the source enable in bit 4 and the target enable in bit 5. The source word at offset 0x4 holds the command in bits 11:1 and the mask in bits 22:12. The target word at offset 0x8 holds min in bits 11:1 and max in bits 22:12. A read returns the stored word, with every unlisted bit reading 0, and a read of any other offset returns 0.
- R10: After reset all three words read 0 and `cnt_pulse` is 0.
- R11: A write to an offset other than 0x0, 0x4 or 0x8 changes no stored word.
- R12: A check whose own enable is 0 does not block events while the master enable is 1, even when its fields hold a blocking configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the configuration words |
| cfg_wr_addr | input | 4 | Byte offset of the word to write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_addr | input | 4 | Byte offset of the word to read |
| cfg_rd_data | output | 32 | Read data, combinational from `cfg_rd_addr` |
| txn_valid | input | 1 | Transaction attributes are valid this cycle |
| txn_event | input | 1 | Event pulse to be qualified |
| txn_tgt_id | input | 11 | Target identifier of the transaction |
| txn_src_id | input | 11 | Source identifier of the transaction |
| txn_tag | input | 1 | Trace-tag flag of the transaction |
| cnt_pulse | output | 1 | Qualified event pulse, one cycle after the input |

## Verification
The bench builds the block with its default parameters: 11-bit identifiers, 32-bit words and offsets 0x0, 0x4 and 0x8. At this width the directed cases can place identifiers exactly on the window bounds and one step outside them. They can also put a masked difference at the low and high bit positions. The random phase keeps identifiers and bounds mostly in a small range so that window hits, misses, empty windows and reversed windows all occur often. It mixes in full-width identifiers, so the upper bits of the compare and of the packed fields are exercised as well.

// File: rtl/evfilt_pkg.sv
package evfilt_pkg;
   // Control word bit positions (software decodes these)
   localparam int unsigned CTL_MASTER_BIT = 1;
   localparam int unsigned CTL_TAG_BIT    = 2;
   localparam int unsigned CTL_SRC_BIT    = 4;
   localparam int unsigned CTL_TGT_BIT    = 5;
   // Packed field positions inside the source and target words
   localparam int unsigned LO_FIELD_LSB   = 1;
   localparam int unsigned HI_FIELD_LSB   = 12;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_SRC  = 2'd2,
      SEL_TGT  = 2'd3
   } word_sel_e;
endpackage

// File: rtl/evfilt_regs.sv
module evfilt_regs
   import evfilt_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ID_W   = 11,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
   parameter logic [ADDR_W-1:0] SRC_OFS  = 'h4,
   parameter logic [ADDR_W-1:0] TGT_OFS  = 'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              master_en,
   output logic              tag_en,
   output logic              src_en,
   output logic              tgt_en,
   output logic [ID_W-1:0]   src_cmd,
   output logic [ID_W-1:0]   src_msk,
   output logic [ID_W-1:0]   tgt_min,
   output logic [ID_W-1:0]   tgt_max
);
   localparam logic [DATA_W-1:0] ONE        = DATA_W'(1);
   localparam logic [DATA_W-1:0] CTRL_MASK  = (ONE << CTL_MASTER_BIT) | (ONE << CTL_TAG_BIT)
                                            | (ONE << CTL_SRC_BIT)    | (ONE << CTL_TGT_BIT);
   localparam logic [DATA_W-1:0] FIELD_ONES = (ONE << ID_W) - ONE;
   localparam logic [DATA_W-1:0] PAIR_MASK  = (FIELD_ONES << LO_FIELD_LSB)
                                            | (FIELD_ONES << HI_FIELD_LSB);

   if (HI_FIELD_LSB + ID_W > DATA_W) begin : g_bad_width
      $error("evfilt_regs: ID_W does not fit in DATA_W");
   end
   if (ID_W + LO_FIELD_LSB > HI_FIELD_LSB) begin : g_bad_overlap
      $error("evfilt_regs: ID_W makes the packed fields overlap");
   end
   if (CTRL_OFS == SRC_OFS || CTRL_OFS == TGT_OFS || SRC_OFS == TGT_OFS) begin : g_bad_map
      $error("evfilt_regs: word offsets must differ");
   end

   logic [DATA_W-1:0] ctrl_q, src_q, tgt_q;
   word_sel_e         wr_sel, rd_sel;

   function automatic word_sel_e decode(input logic [ADDR_W-1:0] a);
      if (a == CTRL_OFS)     return SEL_CTRL;
      else if (a == SRC_OFS) return SEL_SRC;
      else if (a == TGT_OFS) return SEL_TGT;
      else                   return SEL_NONE;
   endfunction

   assign wr_sel = decode(wr_addr);
   assign rd_sel = decode(rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         src_q  <= '0;
         tgt_q  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_CTRL: ctrl_q <= wr_data & CTRL_MASK;
            SEL_SRC:  src_q  <= wr_data & PAIR_MASK;
            SEL_TGT:  tgt_q  <= wr_data & PAIR_MASK;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (rd_sel)
         SEL_CTRL: rd_data = ctrl_q;
         SEL_SRC:  rd_data = src_q;
         SEL_TGT:  rd_data = tgt_q;
         default:  rd_data = '0;
      endcase
   end

   assign master_en = ctrl_q[CTL_MASTER_BIT];
   assign tag_en    = ctrl_q[CTL_TAG_BIT];
   assign src_en    = ctrl_q[CTL_SRC_BIT];
   assign tgt_en    = ctrl_q[CTL_TGT_BIT];
   assign src_cmd   = src_q[LO_FIELD_LSB +: ID_W];
   assign src_msk   = src_q[HI_FIELD_LSB +: ID_W];
   assign tgt_min   = tgt_q[LO_FIELD_LSB +: ID_W];
   assign tgt_max   = tgt_q[HI_FIELD_LSB +: ID_W];

   AST_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q & ~CTRL_MASK) == '0) && ((src_q & ~PAIR_MASK) == '0)) // R9
      else $error("unlisted configuration bit set");
endmodule

// File: rtl/evfilt_match.sv
module evfilt_match #(
   parameter int unsigned ID_W = 11
) (
   input  logic            master_en,
   input  logic            tag_en,
   input  logic            src_en,
   input  logic            tgt_en,
   input  logic [ID_W-1:0] src_cmd,
   input  logic [ID_W-1:0] src_msk,
   input  logic [ID_W-1:0] tgt_min,
   input  logic [ID_W-1:0] tgt_max,
   input  logic [ID_W-1:0] tgt_id,
   input  logic [ID_W-1:0] src_id,
   input  logic            tag,
   output logic            accept
);
   if (ID_W < 1) begin : g_bad_id
      $error("evfilt_match: ID_W must be at least 1");
   end

   logic [ID_W-1:0] src_diff;
   logic            src_ok, tgt_ok, tag_ok, win_ok, in_win;

   // per-bit masked compare; a set mask bit removes that position
   for (genvar b = 0; b < ID_W; b++) begin : g_cmp
      assign src_diff[b] = (src_id[b] ^ src_cmd[b]) & ~src_msk[b];
   end

   assign win_ok = (tgt_max != '0) && (tgt_max >= tgt_min);
   assign in_win = (tgt_id >= tgt_min) && (tgt_id <= tgt_max);

   assign src_ok = !src_en || (src_cmd == '0) || (src_diff == '0);
   assign tgt_ok = !tgt_en || (win_ok && in_win);
   assign tag_ok = !tag_en || tag;

   assign accept = !master_en || (src_ok && tgt_ok && tag_ok);
endmodule

// File: rtl/txn_event_filter.sv
module txn_event_filter #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ID_W   = 11,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
   parameter logic [ADDR_W-1:0] SRC_OFS  = 'h4,
   parameter logic [ADDR_W-1:0] TGT_OFS  = 'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_wr_addr,
   input  logic [DATA_W-1:0] cfg_wr_data,
   input  logic [ADDR_W-1:0] cfg_rd_addr,
   output logic [DATA_W-1:0] cfg_rd_data,
   input  logic              txn_valid,
   input  logic              txn_event,
   input  logic [ID_W-1:0]   txn_tgt_id,
   input  logic [ID_W-1:0]   txn_src_id,
   input  logic              txn_tag,
   output logic              cnt_pulse
);
   logic            master_en, tag_en, src_en, tgt_en, accept, pulse_q;
   logic [ID_W-1:0] src_cmd, src_msk, tgt_min, tgt_max;

   evfilt_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .CTRL_OFS(CTRL_OFS), .SRC_OFS(SRC_OFS), .TGT_OFS(TGT_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
      .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
      .master_en(master_en), .tag_en(tag_en), .src_en(src_en), .tgt_en(tgt_en),
      .src_cmd(src_cmd), .src_msk(src_msk), .tgt_min(tgt_min), .tgt_max(tgt_max)
   );

   evfilt_match #(.ID_W(ID_W)) u_match (
      .master_en(master_en), .tag_en(tag_en), .src_en(src_en), .tgt_en(tgt_en),
      .src_cmd(src_cmd), .src_msk(src_msk), .tgt_min(tgt_min), .tgt_max(tgt_max),
      .tgt_id(txn_tgt_id), .src_id(txn_src_id), .tag(txn_tag),
      .accept(accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= txn_valid && txn_event && accept;
   end

   assign cnt_pulse = pulse_q;

   AST_PULSE_NEEDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse |-> $past(txn_valid && txn_event)) // R1
      else $error("pulse without a transaction event");

   AST_MASTER_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_event && !master_en) |=> cnt_pulse) // R2
      else $error("event dropped with filtering off");

   AST_BAD_WINDOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_event && master_en && tgt_en &&
       (tgt_max == '0 || tgt_max < tgt_min)) |=> !cnt_pulse) // R4
      else $error("event passed an invalid window");

   AST_TAG_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_event && master_en && tag_en && !txn_tag) |=> !cnt_pulse) // R7
      else $error("untagged event passed");
endmodule

// File: tb/txn_event_filter_tb.sv
module txn_event_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [3:0]  cfg_wr_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [3:0]  cfg_rd_addr = '0;
   logic [31:0] cfg_rd_data;
   logic        txn_valid = 1'b0, txn_event = 1'b0, txn_tag = 1'b0;
   logic [10:0] txn_tgt_id = '0, txn_src_id = '0;
   logic        cnt_pulse;

   int unsigned n_run = 0, n_fail = 0;
   bit          done = 0;

   // bench model of the configuration (layout from R9)
   logic [31:0] m_ctrl = '0, m_src = '0, m_tgt = '0;

   always #5 clk = ~clk;

   txn_event_filter u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
      .txn_valid(txn_valid), .txn_event(txn_event),
      .txn_tgt_id(txn_tgt_id), .txn_src_id(txn_src_id), .txn_tag(txn_tag),
      .cnt_pulse(cnt_pulse)
   );

   function automatic bit model_pass(logic [10:0] tid, logic [10:0] sid, logic tg);
      logic [10:0] cmd, msk, mn, mx;
      bit ok;
      cmd = m_src[11:1];  msk = m_src[22:12];
      mn  = m_tgt[11:1];  mx  = m_tgt[22:12];
      if (!m_ctrl[1]) return 1'b1;
      ok = 1'b1;
      if (m_ctrl[2] && !tg) ok = 1'b0;
      if (m_ctrl[4] && cmd != 0 && ((sid ^ cmd) & ~msk) != 0) ok = 1'b0;
      if (m_ctrl[5] && (mx == 0 || mx < mn || tid < mn || tid > mx)) ok = 1'b0;
      return ok;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      txn_valid = 1'b0; txn_event = 1'b0;
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      case (a)
         4'h0: m_ctrl = d & 32'h0000_0036;
         4'h4: m_src  = d & 32'h007F_FFFE;
         4'h8: m_tgt  = d & 32'h007F_FFFE;
         default: ;
      endcase
   endtask

   task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
      cfg_rd_addr = a;
      #1;
      check(req, cfg_rd_data, exp);
   endtask

   // drive one cycle of transaction, then check the registered pulse
   task automatic ev(string req, logic [10:0] tid, logic [10:0] sid, logic tg,
                     logic v, logic e, int exp_override);
      bit exp;
      @(negedge clk);
      txn_valid = v; txn_event = e; txn_tgt_id = tid; txn_src_id = sid; txn_tag = tg;
      exp = v && e && model_pass(tid, sid, tg);
      if (exp_override >= 0 && exp != bit'(exp_override[0])) begin
         n_fail++;
         $display("FAIL %s: bench model %0d expected %0d", req, exp, exp_override);
      end
      @(negedge clk);
      check(req, {31'd0, cnt_pulse}, {31'd0, exp});
      txn_valid = 1'b0; txn_event = 1'b0;
   endtask

   function automatic logic [31:0] pair(logic [10:0] lo, logic [10:0] hi);
      return ({21'd0, lo} << 1) | ({21'd0, hi} << 12);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", {31'd0, cnt_pulse}, 32'd0);
      rst_n = 1'b1;
      rd_chk("R10", 4'h0, 32'd0);
      rd_chk("R10", 4'h4, 32'd0);
      rd_chk("R10", 4'h8, 32'd0);

      // R9: layout and readback
      wr(4'h0, 32'hFFFF_FFFF);
      rd_chk("R9", 4'h0, 32'h0000_0036);
      wr(4'h4, pair(11'h5A5, 11'h00F));
      rd_chk("R9", 4'h4, 32'h0000_FB4A);
      wr(4'h8, 32'hFFFF_FFFF);
      rd_chk("R9", 4'h8, 32'h007F_FFFE);
      rd_chk("R9", 4'hC, 32'd0);
      // R11: unmapped write changes nothing
      wr(4'hC, 32'hFFFF_FFFF);
      wr(4'h2, 32'h0000_0000);
      rd_chk("R11", 4'h0, 32'h0000_0036);
      rd_chk("R11", 4'h4, 32'h0000_FB4A);
      rd_chk("R11", 4'h8, 32'h007F_FFFE);

      // R2: master off passes everything despite blocking fields
      wr(4'h0, 32'h0000_0034);
      wr(4'h8, pair(11'd6, 11'd5));
      ev("R2", 11'd7, 11'h000, 1'b0, 1'b1, 1'b1, 1);
      // R1: strobes and single-cycle pulse
      ev("R1", 11'd7, 11'h000, 1'b0, 1'b0, 1'b1, 0);
      ev("R1", 11'd7, 11'h000, 1'b0, 1'b1, 1'b0, 0);
      ev("R1", 11'd7, 11'h000, 1'b0, 1'b1, 1'b1, 1);
      @(negedge clk);
      check("R1", {31'd0, cnt_pulse}, 32'd0);

      // R3: inclusive window 10..20
      wr(4'h0, 32'h0000_0022);
      wr(4'h8, pair(11'd10, 11'd20));
      ev("R3", 11'd9,  11'h0, 1'b0, 1'b1, 1'b1, 0);
      ev("R3", 11'd10, 11'h0, 1'b0, 1'b1, 1'b1, 1);
      ev("R3", 11'd20, 11'h0, 1'b0, 1'b1, 1'b1, 1);
      ev("R3", 11'd21, 11'h0, 1'b0, 1'b1, 1'b1, 0);
      // R4: invalid windows
      wr(4'h8, pair(11'd0, 11'd0));
      ev("R4", 11'd0, 11'h0, 1'b0, 1'b1, 1'b1, 0);
      wr(4'h8, pair(11'd6, 11'd5));
      ev("R4", 11'd5, 11'h0, 1'b0, 1'b1, 1'b1, 0);
      ev("R4", 11'd6, 11'h0, 1'b0, 1'b1, 1'b1, 0);
      // R12: target enable off, blocking window ignored
      wr(4'h0, 32'h0000_0002);
      ev("R12", 11'd5, 11'h0, 1'b0, 1'b1, 1'b1, 1);

      // R5: masked source compare
      wr(4'h0, 32'h0000_0012);
      wr(4'h4, pair(11'h0A5, 11'h00F));
      ev("R5", 11'd0, 11'h0A0, 1'b0, 1'b1, 1'b1, 1);
      ev("R5", 11'd0, 11'h1A5, 1'b0, 1'b1, 1'b1, 0);
      ev("R5", 11'd0, 11'h4A5, 1'b0, 1'b1, 1'b1, 0);
      // R6: zero command accepts all
      wr(4'h4, pair(11'h000, 11'h000));
      ev("R6", 11'd0, 11'h7FF, 1'b0, 1'b1, 1'b1, 1);

      // R7: trace tag
      wr(4'h0, 32'h0000_0006);
      ev("R7", 11'd0, 11'h0, 1'b0, 1'b1, 1'b1, 0);
      ev("R7", 11'd0, 11'h0, 1'b1, 1'b1, 1'b1, 1);

      // R8: all checks combined
      wr(4'h0, 32'h0000_0036);
      wr(4'h4, pair(11'h300, 11'h0FF));
      wr(4'h8, pair(11'd100, 11'd1500));
      ev("R8", 11'd800, 11'h3AB, 1'b1, 1'b1, 1'b1, 1);
      ev("R8", 11'd800, 11'h3AB, 1'b0, 1'b1, 1'b1, 0);
      ev("R8", 11'd800, 11'h2AB, 1'b1, 1'b1, 1'b1, 0);
      ev("R8", 11'd1501, 11'h3AB, 1'b1, 1'b1, 1'b1, 0);

      // R8: random mix against the bench model
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 19) == 0) begin
            case ($urandom_range(0, 2))
               0: wr(4'h0, ($urandom_range(0, 7) == 0) ? $urandom : ($urandom | 32'h2));
               1: wr(4'h4, pair(($urandom_range(0, 3) == 0) ? 11'd0 : 11'($urandom_range(0, 15)),
                                11'($urandom_range(0, 15) & $urandom_range(0, 15))));
               default: wr(4'h8, pair(11'($urandom_range(0, 63)), 11'($urandom_range(0, 63))));
            endcase
         end else begin
            ev("R8",
               ($urandom_range(0, 9) == 0) ? 11'($urandom) : 11'($urandom_range(0, 63)),
               ($urandom_range(0, 9) == 0) ? 11'($urandom) : 11'($urandom_range(0, 15)),
               1'($urandom), ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0), -1);
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule